// File: doc/BRIEF.md
# Qualified Serial-Bit Receive Buffer

This block buffers demodulated receive bits, one bit per entry, in a 64-deep first-in first-out store. Bits that arrive with the bit strobe are thrown away until a qualifying event opens the buffer. A qualifying event is a data-valid indication or a sync-word match. After that, every strobed bit is stored until software pulses the clear input. In this way line noise that comes before a real frame never reaches the buffer.

A host drains the buffer directly. It holds the select input low and toggles the shift clock, and each rising edge of the shift clock removes the oldest bit and presents it on the read output. The block compares the fill level with a programmable threshold and drives a level interrupt from the result. With the threshold at 1, a poller can keep reading until the interrupt drops. The block also reports an empty flag and a sticky overflow flag.

The buffer-enable logic is a two-state machine:
- `GATE_DISCARD` is the reset state. Strobed bits are dropped in this state.
- `GATE_STORE` stores strobed bits.

There are two transitions:
- *open*: `GATE_DISCARD` → `GATE_STORE`. It happens when `valid_ind` or `sync_hit` is high and `clr` is low.
- *close*: `GATE_STORE` → `GATE_DISCARD`. It happens when `clr` is high.

Top module: `gated_bit_fifo`

## Requirements
- R1: After reset, `empty`=1, `ovf`=0, `rd_bit`=0 and the gate is in `GATE_DISCARD`.
- R2: While the gate is closed, strobed bits are not stored. A bit strobed in the same cycle as the qualifying event is also discarded, because the gate opens one clock later.
- R3: Once opened by `valid_ind` or `sync_hit`, the gate stays open until `clr`. Each strobed bit is stored, and bits are read back in arrival order.
- R4: `lvl_irq` is 1 exactly when the stored count (0..64) is greater than or equal to the 7-bit `lvl_thr`. With `lvl_thr`=1, it stays high while any bit remains.
- R5: `empty` is 1 exactly when no bits are stored.
- R6: A strobed bit that arrives while the gate is open, the buffer holds 64 bits and no pop happens in that cycle is dropped. The stored bits are unchanged, and `ovf` is set and stays set until `clr`.
- R7: A pop is a rising edge of `rd_sck`, seen at a clock edge, while `rd_sel_n`=0. `rd_bit` shows the popped oldest bit from that clock edge on. Edges of `rd_sck` while `rd_sel_n`=1 have no effect.
- R8: A pop from an empty buffer drives `rd_bit` to 0 and changes no other state.
- R9: A push and a pop in the same cycle leave the count unchanged. This holds even when the buffer is full, and no overflow is raised in that case.
- R10: `clr` empties the buffer, clears `ovf`, returns the gate to `GATE_DISCARD` and drives `rd_bit` to 0. It takes precedence over a qualifying event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of buffer, overflow and gate |
| bit_in | input | 1 | Demodulated data bit |
| bit_stb | input | 1 | One-cycle strobe marking a valid `bit_in` |
| valid_ind | input | 1 | Data-valid indication (qualifier) |
| sync_hit | input | 1 | Sync-word match (qualifier) |
| lvl_thr | input | 7 | Fill threshold for the level interrupt |
| rd_sel_n | input | 1 | Active-low read-port select |
| rd_sck | input | 1 | Read shift clock, synchronous to `clk` |
| rd_bit | output | 1 | Last popped bit |
| lvl_irq | output | 1 | Fill level at or above threshold |
| empty | output | 1 | No bits stored |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions check four things on every cycle:
- The gate stays open until a clear.
- A clear empties the buffer and resets the flags.
- Overflow is sticky.
- The read pointer and count do not move when a pop hits an empty buffer or when a push and a pop coincide.

Three behaviours can only be shown by the bench scenarios, which compare against a queue model:
- Bits come out in arrival order.
- Unqualified bits are discarded, including the bit that arrives together with the qualifier.
- The threshold comparison is correct across levels, and stored contents survive an overflow.

// File: rtl/gbf_pkg.sv
package gbf_pkg;

    typedef enum logic {
        GATE_DISCARD = 1'b0,
        GATE_STORE   = 1'b1
    } gate_state_t;

endpackage

// File: rtl/gbf_gate.sv
module gbf_gate
    import gbf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic valid_ind,
    input  logic sync_hit,
    output logic wr_en
);

    gate_state_t state_q, state_d;

    // Next-state logic: open on a qualifier, close on clear.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_DISCARD: if (!clr && (valid_ind || sync_hit)) state_d = GATE_STORE;
            GATE_STORE:   if (clr)                              state_d = GATE_DISCARD;
            default:                                            state_d = GATE_DISCARD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_DISCARD;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            GATE_DISCARD: wr_en = 1'b0;
            GATE_STORE:   wr_en = 1'b1;
            default:      wr_en = 1'b0;
        endcase
    end

    // R3
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_STORE && !clr) |=> state_q == GATE_STORE);

    // R10
    gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> state_q == GATE_DISCARD);

endmodule

// File: rtl/gbf_rdport.sv
module gbf_rdport (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic sck,
    output logic pop_req
);

    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign pop_req = sck && !sck_q && !sel_n;

    // R7
    pop_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !pop_req);

endmodule

// File: rtl/gbf_store.sv
module gbf_store #(
    parameter  int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push_req,
    input  logic             bit_in,
    input  logic             pop_req,
    input  logic [CNT_W-1:0] thr,
    output logic             rd_bit,
    output logic             lvl_irq,
    output logic             empty,
    output logic             ovf
);

    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    logic [DEPTH-1:0] mem;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, push_ok, pop_ok;

    assign full    = (count == FULLC);
    assign empty   = (count == '0);
    assign pop_ok  = pop_req && !empty;
    assign push_ok = push_req && (!full || pop_ok);
    assign lvl_irq = (count >= thr);

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= bit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            rd_bit <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            rd_bit <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (pop_req) rd_bit <= pop_ok ? mem[rd_ptr] : 1'b0;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
            if (push_req && !push_ok) ovf <= 1'b1;
        end
    end

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULLC);

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_req && !clr) |=> (empty && !rd_bit && $stable(rd_ptr)));

    // R9
    pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !empty && !clr) |=> ($stable(count) && !$rose(ovf)));

    // R7
    rdptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_req && !clr) |=> $stable(rd_ptr));

    // R10
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !ovf && !rd_bit));

endmodule

// File: rtl/gated_bit_fifo.sv
module gated_bit_fifo #(
    parameter  int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_in,
    input  logic             bit_stb,
    input  logic             valid_ind,
    input  logic             sync_hit,
    input  logic [CNT_W-1:0] lvl_thr,
    input  logic             rd_sel_n,
    input  logic             rd_sck,
    output logic             rd_bit,
    output logic             lvl_irq,
    output logic             empty,
    output logic             ovf
);

    logic wr_en;
    logic pop_req;

    gbf_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .valid_ind (valid_ind),
        .sync_hit  (sync_hit),
        .wr_en     (wr_en)
    );

    gbf_rdport u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (rd_sel_n),
        .sck     (rd_sck),
        .pop_req (pop_req)
    );

    gbf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .push_req (bit_stb && wr_en),
        .bit_in   (bit_in),
        .pop_req  (pop_req),
        .thr      (lvl_thr),
        .rd_bit   (rd_bit),
        .lvl_irq  (lvl_irq),
        .empty    (empty),
        .ovf      (ovf)
    );

    // R2
    no_store_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && empty && !clr) |=> empty);

endmodule

// File: tb/gated_bit_fifo_tb.sv
module gated_bit_fifo_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0, bit_in = 1'b0, bit_stb = 1'b0;
    logic       valid_ind = 1'b0, sync_hit = 1'b0;
    logic [6:0] lvl_thr = 7'd1;
    logic       rd_sel_n = 1'b0, rd_sck = 1'b0;
    logic       rd_bit, lvl_irq, empty, ovf;

    int  n_chk = 0, n_bad = 0;
    bit  m_q[$];
    bit  exp_rd[$];
    bit  m_en = 0, m_ovf = 0;
    bit  sck_seen = 0;

    always #5 clk = ~clk;

    gated_bit_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(bit_in), .bit_stb(bit_stb),
        .valid_ind(valid_ind), .sync_hit(sync_hit), .lvl_thr(lvl_thr),
        .rd_sel_n(rd_sel_n), .rd_sck(rd_sck), .rd_bit(rd_bit),
        .lvl_irq(lvl_irq), .empty(empty), .ovf(ovf)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compares each popped bit against the scoreboard queue (R7, R8)
    always @(posedge clk) begin
        logic fire;
        fire = rst_n && rd_sck && !sck_seen && !rd_sel_n;
        sck_seen = rd_sck && rst_n;
        if (fire) begin
            #2;
            if (exp_rd.size() > 0) check("R7 read data", rd_bit, exp_rd.pop_front());
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic void model_push(bit b, bit popped);
        if (!m_en) return;
        if (m_q.size() < 64 || popped) m_q.push_back(b);
        else m_ovf = 1;
    endfunction

    task automatic send_bit(input bit b);
        bit_in = b; bit_stb = 1'b1;
        @(posedge clk);
        model_push(b, 0);
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic pop_one();
        exp_rd.push_back(m_q.size() > 0 ? m_q.pop_front() : 1'b0);
        rd_sck = 1'b1;
        tick();
        rd_sck = 1'b0;
        tick();
    endtask

    task automatic push_pop(input bit b);
        bit popped;
        popped = m_q.size() > 0;
        exp_rd.push_back(popped ? m_q.pop_front() : 1'b0);
        bit_in = b; bit_stb = 1'b1; rd_sck = 1'b1;
        @(posedge clk);
        model_push(b, popped);
        @(negedge clk);
        bit_stb = 1'b0; rd_sck = 1'b0;
        tick();
    endtask

    task automatic check_level(input string req, input int n);
        lvl_thr = 7'(n);
        #1 check(req, lvl_irq, 1);
        lvl_thr = 7'(n + 1);
        #1 check(req, lvl_irq, 0);
        lvl_thr = 7'd1;
        #1;
    endtask

    task automatic do_clr();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        m_q.delete(); m_en = 0; m_ovf = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 empty", empty, 1);
        check("R1 ovf", ovf, 0);
        check("R1 rd_bit", rd_bit, 0);
        check("R1 lvl_irq", lvl_irq, 0);

        // R2 unqualified bits discarded
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        check("R2 closed gate", empty, 1);
        // R8 pop from empty returns 0
        pop_one();
        check("R8 empty after pop", empty, 1);

        // R2 bit together with qualifier is dropped
        valid_ind = 1'b1; bit_in = 1'b1; bit_stb = 1'b1;
        tick();
        valid_ind = 1'b0; bit_stb = 1'b0; m_en = 1;
        check("R2 same-cycle bit", empty, 1);

        // R3 R4 R5 store a pattern, then poll-drain
        for (int i = 0; i < 10; i++) send_bit(bit'((10'b1011001110 >> i) & 1));
        check("R5 not empty", empty, 0);
        check_level("R4 level 10", 10);
        begin
            int pops = 0;
            lvl_thr = 7'd1;
            #1;
            while (lvl_irq && pops < 80) begin
                pop_one();
                pops++;
            end
            check("R4 polling count", pops, 10);
        end
        check("R5 empty after drain", empty, 1);

        // R7 edges ignored while deselected
        for (int i = 0; i < 3; i++) send_bit(bit'(i & 1));
        rd_sel_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            rd_sck = 1'b1; tick(); rd_sck = 1'b0; tick();
        end
        rd_sel_n = 1'b0;
        check_level("R7 deselected", 3);

        // R9 simultaneous push and pop
        push_pop(1'b1);
        check_level("R9 count unchanged", 3);
        for (int i = 0; i < 3; i++) pop_one();
        check("R3 drained", empty, 1);

        // R6 R9 fill to 64, push+pop at full, then overflow
        for (int i = 0; i < 64; i++) send_bit(bit'((i % 3 == 0) ^ ((i >> 4) & 1)));
        check_level("R3 full level", 64);
        push_pop(1'b0);
        check("R9 no ovf at full", ovf, 0);
        check_level("R9 full count", 64);
        send_bit(1'b1);
        check("R6 ovf set", ovf, m_ovf);
        check_level("R6 content kept", 64);
        for (int i = 0; i < 64; i++) pop_one();
        check("R6 ovf sticky", ovf, 1);
        check("R5 empty", empty, 1);

        // R10 clear wins over qualifier
        clr = 1'b1; sync_hit = 1'b1;
        tick();
        clr = 1'b0; sync_hit = 1'b0;
        m_q.delete(); m_en = 0; m_ovf = 0;
        check("R10 ovf cleared", ovf, 0);
        check("R10 rd_bit", rd_bit, 0);
        send_bit(1'b1);
        check("R10 gate closed", empty, 1);
        sync_hit = 1'b1; tick(); sync_hit = 1'b0; m_en = 1;
        send_bit(1'b1); send_bit(1'b0);
        check("R3 sync opens", empty, 0);
        do_clr();
        check("R10 emptied", empty, 1);
        send_bit(1'b0);
        check("R10 gate reclosed", empty, 1);

        tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule